// File: doc/BRIEF.md
# Power-down and output-valid sequencer

This block decides when the serial data output of a sample-rate path may carry real samples. It watches an active-low power-down input and a flag that reports that the input clock is locked and its rate has been measured. From these, and from a once-per-frame strobe, it drives an output-enable. Downstream logic uses that enable to force the serial output to zero. It also emits a one-cycle pulse that clears the state of the digital filter.

The sequencer moves through four states: power-down, acquisition (waiting for lock), settling, and normal operation. After release from power-down, the output stays at zero until lock is seen. It then stays at zero for a programmable number of frame strobes. Any loss of lock while settling or running sends the sequencer back to acquisition with a fresh filter clear. The output is then held at zero again until a full settling delay has passed.

The power-down and lock inputs come from other clock domains or from pins. Each passes through a synchronizer of `SYNC_STAGES` flops. The exception is the gating of the output-enable by power-down, which acts at once, without waiting for a clock edge.

Top module: `pwr_valid_seq`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released while pd_ni stays low, out_en_o and flt_init_o are both 0.
- R2: Whenever pd_ni is 0, out_en_o is 0 within the same time step, with no clock edge needed.
- R3: With the default SYNC_STAGES=2, a falling pd_ni captured before clock edge k makes flt_init_o 1 after edge k+2 and 0 again after edge k+3. The pulse lasts exactly one cycle.
- R4: After release from power-down, out_en_o stays 0 for as long as lock_i is 0, and frame strobes that arrive while lock_i is 0 are not counted.
- R5: Once lock is seen, the block counts cycles with frame_stb_i=1. out_en_o rises at the clock edge after the edge that samples the strobe numbered valid_dly_i, and not earlier.
- R6: With valid_dly_i=0, out_en_o rises one clock after the settling state is entered, with no strobe needed.
- R7: In normal operation, lock_i falling before edge k (default synchronizer) drops out_en_o and raises flt_init_o for one cycle after edge k+2. out_en_o is still 1 after edge k+1.
- R8: Loss of lock during settling pulses flt_init_o and clears the strobe count. After lock returns, a full valid_dly_i strobes are needed again.
- R9: Release of power-down (the move into acquisition from power-down) produces no flt_init_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Active-low power-down request |
| lock_i | input | 1 | Input clock locked and rate detected |
| valid_dly_i | input | CNT_W | Number of frame strobes to wait after lock |
| frame_stb_i | input | 1 | One-cycle strobe per output frame |
| flt_init_o | output | 1 | One-cycle filter initialize pulse |
| out_en_o | output | 1 | 1 lets data through, 0 forces output to zero |

## Verification
The hardest situation to reach is a loss of lock partway through settling, followed by a recovery. A counter that keeps its partial count would look correct in every simpler scenario. The stimulus gives two of three required strobes and then drops lock for enough cycles to pass the synchronizer. It then restores lock and gives two strobes again. The enable must still be low one cycle later, and must rise only after a third strobe.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
  typedef enum logic [1:0] {
    ST_PD     = 2'd0,
    ST_ACQ    = 2'd1,
    ST_SETTLE = 2'd2,
    ST_RUN    = 2'd3
  } pvs_state_e;
endpackage

// File: rtl/pvs_sync.sv
module pvs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pvs_settle_cnt.sv
module pvs_settle_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= dly_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (stb_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pvs_fsm.sv
module pvs_fsm
  import pvs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_s_i,
  input  logic       lock_s_i,
  input  logic       settle_done_i,
  output pvs_state_e st_o,
  output logic       flt_init_o
);
  pvs_state_e st_q, st_d;
  logic       init_d, init_q;

  always_comb begin
    st_d = st_q;
    if (!pd_s_i) st_d = ST_PD;
    else begin
      unique case (st_q)
        ST_PD:     st_d = ST_ACQ;
        ST_ACQ:    if (lock_s_i) st_d = ST_SETTLE;
        ST_SETTLE: if (!lock_s_i) st_d = ST_ACQ;
                   else if (settle_done_i) st_d = ST_RUN;
        ST_RUN:    if (!lock_s_i) st_d = ST_ACQ;
        default:   st_d = ST_PD;
      endcase
    end
  end

  // clear filter on power-down entry and on lock loss, not on release
  always_comb begin
    init_d = 1'b0;
    if (st_d == ST_PD && st_q != ST_PD) init_d = 1'b1;
    if (st_d == ST_ACQ && (st_q == ST_SETTLE || st_q == ST_RUN)) init_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PD;
      init_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      init_q <= init_d;
    end
  end

  assign st_o       = st_q;
  assign flt_init_o = init_q;
endmodule

// File: rtl/pwr_valid_seq.sv
module pwr_valid_seq
  import pvs_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             lock_i,
  input  logic [CNT_W-1:0] valid_dly_i,
  input  logic             frame_stb_i,
  output logic             flt_init_o,
  output logic             out_en_o
);
  localparam int unsigned NSIG = 2;

  logic [NSIG-1:0] raw, synced;
  logic            pd_s, lock_s, settle_done;
  pvs_state_e      st;

  assign raw    = {lock_i, pd_ni};
  assign pd_s   = synced[0];
  assign lock_s = synced[1];

  pvs_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  pvs_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st != ST_SETTLE),
    .stb_i (frame_stb_i),
    .dly_i (valid_dly_i),
    .done_o(settle_done)
  );

  pvs_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_s_i       (pd_s),
    .lock_s_i     (lock_s),
    .settle_done_i(settle_done),
    .st_o         (st),
    .flt_init_o   (flt_init_o)
  );

  // raw pd_ni gates the enable without waiting for the synchronizer
  assign out_en_o = (st == ST_RUN) && pd_ni;
endmodule

// File: rtl/pwr_valid_seq_chk.sv
module pwr_valid_seq_chk
  import pvs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pd_ni,
  input logic       pd_s,
  input logic       lock_s,
  input pvs_state_e st,
  input logic       flt_init_o,
  input logic       out_en_o
);
  always_comb
    if (rst_ni && !pd_ni) AST_PD_FORCES_OFF: assert (!out_en_o); // R2

  AST_INIT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_init_o |=> !flt_init_o); // R3

  AST_LOCK_LOSS_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_s && !lock_s && (st == ST_SETTLE || st == ST_RUN)) |=> (flt_init_o && st == ST_ACQ)); // R7

  AST_RUN_FROM_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_RUN && $past(st) != ST_RUN) |-> $past(st) == ST_SETTLE); // R5

  AST_NO_INIT_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st) == ST_PD && st == ST_ACQ) |-> !flt_init_o); // R9

  AST_UNLOCKED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACQ) |-> !out_en_o); // R4
endmodule

bind pwr_valid_seq pwr_valid_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pd_ni     (pd_ni),
  .pd_s      (pd_s),
  .lock_s    (lock_s),
  .st        (st),
  .flt_init_o(flt_init_o),
  .out_en_o  (out_en_o)
);

// File: tb/pwr_valid_seq_bench.sv
module pwr_valid_seq_bench;
  localparam int unsigned CNT_W = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pd_ni = 1'b0;
  logic             lock_i = 1'b0;
  logic [CNT_W-1:0] valid_dly_i = '0;
  logic             frame_stb_i = 1'b0;
  logic             flt_init_o, out_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwr_valid_seq #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_pwr_valid_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_ni(pd_ni), .lock_i(lock_i),
    .valid_dly_i(valid_dly_i), .frame_stb_i(frame_stb_i),
    .flt_init_o(flt_init_o), .out_en_o(out_en_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic strobe();
    frame_stb_i = 1'b1;
    @(negedge clk_i);
    frame_stb_i = 1'b0;
  endtask

  task automatic go_pd();
    @(negedge clk_i);
    pd_ni = 1'b0;
    wait_n(6);
  endtask

  // release with lock already high: SETTLE after 4 negedges
  task automatic bring_up(input int dly);
    valid_dly_i = CNT_W'(dly);
    lock_i = 1'b1;
    pd_ni = 1'b1;
    wait_n(4);
  endtask

  task automatic t_reset();
    chk("R1 out_en in reset", out_en_o, 1'b0);
    chk("R1 flt_init in reset", flt_init_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wait_n(3);
    chk("R1 out_en after reset", out_en_o, 1'b0);
    chk("R1 flt_init after reset", flt_init_o, 1'b0);
  endtask

  task automatic t_release_no_init();
    valid_dly_i = CNT_W'(3);
    lock_i = 1'b1;
    pd_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R9 no init on release", flt_init_o, 1'b0);
    end
    go_pd();
  endtask

  task automatic t_unlocked_then_settle();
    valid_dly_i = CNT_W'(3);
    lock_i = 1'b0;
    pd_ni = 1'b1;
    wait_n(6);
    repeat (3) strobe();
    wait_n(2);
    chk("R4 unlocked stays off", out_en_o, 1'b0);
    lock_i = 1'b1;
    wait_n(3);
    wait_n(3);
    chk("R4 strobes while unlocked ignored", out_en_o, 1'b0);
    strobe();
    strobe();
    wait_n(1);
    chk("R5 off after 2 of 3 strobes", out_en_o, 1'b0);
    strobe();
    chk("R5 off on edge of 3rd strobe", out_en_o, 1'b0);
    wait_n(1);
    chk("R5 on after 3rd strobe", out_en_o, 1'b1);
  endtask

  task automatic t_lock_loss_run();
    @(negedge clk_i);
    lock_i = 1'b0;
    wait_n(2);
    chk("R7 still on after k+1", out_en_o, 1'b1);
    chk("R7 no init yet", flt_init_o, 1'b0);
    wait_n(1);
    chk("R7 off after k+2", out_en_o, 1'b0);
    chk("R7 init pulse", flt_init_o, 1'b1);
    wait_n(1);
    chk("R7 init one cycle", flt_init_o, 1'b0);
    lock_i = 1'b1;
    wait_n(3);
    repeat (3) strobe();
    wait_n(1);
    chk("R7 recovers after strobes", out_en_o, 1'b1);
  endtask

  task automatic t_powerdown();
    @(negedge clk_i);
    pd_ni = 1'b0;
    #1;
    chk("R2 immediate off", out_en_o, 1'b0);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R3 no init at k+1", flt_init_o, 1'b0);
    @(negedge clk_i);
    chk("R3 init at k+2", flt_init_o, 1'b1);
    @(negedge clk_i);
    chk("R3 init one cycle", flt_init_o, 1'b0);
    lock_i = 1'b1;
    repeat (4) strobe();
    chk("R3 held in power-down", out_en_o, 1'b0);
    wait_n(2);
  endtask

  task automatic t_zero_delay();
    bring_up(0);
    chk("R6 off on settle entry", out_en_o, 1'b0);
    wait_n(1);
    chk("R6 on with zero delay", out_en_o, 1'b1);
    go_pd();
  endtask

  task automatic t_lock_loss_settle();
    bring_up(3);
    strobe();
    strobe();
    lock_i = 1'b0;
    wait_n(3);
    chk("R8 init on settle lock loss", flt_init_o, 1'b1);
    lock_i = 1'b1;
    wait_n(3);
    strobe();
    strobe();
    wait_n(1);
    chk("R8 count cleared", out_en_o, 1'b0);
    strobe();
    wait_n(1);
    chk("R8 on after full count", out_en_o, 1'b1);
    go_pd();
  endtask

  initial begin
    wait_n(3);
    t_reset();
    t_release_no_init();
    t_unlocked_then_settle();
    t_lock_loss_run();
    t_powerdown();
    t_zero_delay();
    t_lock_loss_settle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule